// File: doc/BRIEF.md
# Isochronous Transmit Header-Insertion Sequencer

This block drives the transmit side of a streaming data-mover port that sends isochronous packets with the header inserted automatically. A clean one-cycle pulse on `ready_i` starts a transfer. The block samples the channel mask and the payload length, then serves every channel whose mask bit is set, lowest number first. For each channel it loads the stored header word, writes the channel number into it, announces the packet with a one-cycle start strobe, and then moves the payload words out of a local buffer. A word moves only in a cycle where the link side raises its read-enable.

The header word lives in a small configuration space and is written through a simple write port. When the last channel's payload has gone out, the block waits a fixed number of idle cycles. Only then does it raise `done_o` again. `done_o` drops as soon as a transfer is accepted. While a transfer runs, any new ready pulse is ignored.

Top module: `iso_tx_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `done_o` is 1 and both `pkt_start_o` and `tx_valid_o` are 0. Asserting `rst_ni` in the middle of a transfer returns the block to this idle state.
- R2: A transfer starts only when `ready_i` is high for exactly one cycle. If `ready_i` stays high for two or more cycles, no transfer starts and `done_o` stays 1.
- R3: The edge that detects the falling end of the ready pulse clears `done_o`. It then stays 0 until the transfer completes. It is 0 whenever `pkt_start_o` is 1.
- R4: The header comes from the configuration word at offset 0x38 (`cfg_addr_i` = 8'h38). Writes to any other offset leave it unchanged. `hdr_o` holds steady for the whole payload of a packet.
- R5: Each packet opens with `pkt_start_o` high for exactly one cycle, and no payload word moves in that cycle. From that cycle on, `hdr_o` carries the stored header with bits [13:8] replaced by the channel number.
- R6: A payload word moves (`tx_valid_o`=1) only in a cycle where `rd_en_i` is 1. `buf_addr_o` gives the word index, starting at 0. `tx_data_o` equals `buf_data_i`.
- R7: Each packet carries `len_m1_i`+1 words, where `len_m1_i` is sampled at the start. This covers 1 to 256 words.
- R8: Every channel n with bit n set in `chan_mask_i` (sampled at the start) is sent once, in ascending order of n.
- R9: `done_o` returns to 1 exactly GAP_CYC cycles (default 4) after the edge that takes the last payload word.
- R10: If the mask is all zeros, no packet is sent. `done_o` returns to 1 GAP_CYC cycles after the start edge.
- R11: A ready pulse that arrives during a transfer does not change that transfer and starts no further transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset (header at 0x38) |
| cfg_wdata_i | input | 32 | Configuration write data |
| chan_mask_i | input | 64 | Channel set; bit n enables channel n |
| len_m1_i | input | 8 | Payload words per packet minus one |
| ready_i | input | 1 | One-cycle transfer start pulse |
| rd_en_i | input | 1 | Link-side read-enable for payload words |
| buf_data_i | input | 32 | Payload word read from the local buffer |
| done_o | output | 1 | High when idle and after a completed transfer |
| pkt_start_o | output | 1 | One-cycle packet-start strobe |
| hdr_o | output | 32 | Header of the current packet with channel inserted |
| buf_addr_o | output | 8 | Word index into the local buffer |
| tx_data_o | output | 32 | Payload word handed to the link side |
| tx_valid_o | output | 1 | A payload word moves this cycle |

## Verification
A wrong state or a lost channel bit shows up at the ports within one packet. It appears as a missing or doubled `pkt_start_o`, a channel field out of order in `hdr_o`, or a packet whose word count differs from the programmed length. A fault in the word counter shows at once as a `buf_addr_o` that skips or repeats. A fault in the gap timer moves the rising edge of `done_o` by at least one cycle, and the cycle count from the last word catches that. The bench therefore follows every packet word by word and times `done_o` against the last taken word.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PRE,
    ST_PAYLOAD,
    ST_GAP
  } seq_state_e;
endpackage

// File: rtl/iso_hdr_reg.sv
module iso_hdr_reg #(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  HDR_OFFSET = 8'h38,
  parameter int          CH_W       = 6,
  parameter int          CH_LSB     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  input  logic [CH_W-1:0]   ch_i,
  output logic [DATA_W-1:0] hdr_o
);
  logic [DATA_W-1:0] stored_q;
  logic [DATA_W-1:0] hdr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stored_q <= '0;
    else if (we_i && addr_i == ADDR_W'(HDR_OFFSET)) stored_q <= wdata_i;
  end

  always_comb begin
    hdr_d = stored_q;
    hdr_d[CH_LSB +: CH_W] = ch_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hdr_o <= '0;
    else if (load_i) hdr_o <= hdr_d;
  end
endmodule

// File: rtl/iso_chan_pick.sv
module iso_chan_pick #(
  parameter int NUM_CHAN = 64,
  parameter int CH_W     = $clog2(NUM_CHAN)
) (
  input  logic [NUM_CHAN-1:0] pend_i,
  output logic                any_o,
  output logic [CH_W-1:0]     idx_o
);
  // lowest pending channel wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_CHAN - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = CH_W'(i);
    end
    any_o = |pend_i;
  end
endmodule

// File: rtl/iso_word_ctr.sv
module iso_word_ctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] len_m1_i,
  output logic [LEN_W-1:0] cnt_o,
  output logic             last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

  assign last_o = (cnt_o == len_m1_i);
endmodule

// File: rtl/iso_tx_seq.sv
module iso_tx_seq
  import iso_tx_pkg::*;
#(
  parameter int         NUM_CHAN   = 64,
  parameter int         LEN_W      = 8,
  parameter int         DATA_W     = 32,
  parameter int         CFG_AW     = 8,
  parameter logic [7:0] HDR_OFFSET = 8'h38,
  parameter int         CH_LSB     = 8,
  parameter int         GAP_CYC    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  input  logic [NUM_CHAN-1:0] chan_mask_i,
  input  logic [LEN_W-1:0]    len_m1_i,
  input  logic                ready_i,
  input  logic                rd_en_i,
  input  logic [DATA_W-1:0]   buf_data_i,
  output logic                done_o,
  output logic                pkt_start_o,
  output logic [DATA_W-1:0]   hdr_o,
  output logic [LEN_W-1:0]    buf_addr_o,
  output logic [DATA_W-1:0]   tx_data_o,
  output logic                tx_valid_o
);
  localparam int CH_W  = $clog2(NUM_CHAN);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  seq_state_e          state_q;
  logic                ready_q, ready_qq;
  logic                start;
  logic [NUM_CHAN-1:0] pend_q;
  logic [LEN_W-1:0]    len_q;
  logic [GAP_W-1:0]    gap_q;
  logic                done_q;
  logic                pick_any;
  logic [CH_W-1:0]     pick_idx;
  logic                take, last_word;
  logic [LEN_W-1:0]    word_cnt;

  // R2: accept only a pulse of exactly one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q  <= 1'b0;
      ready_qq <= 1'b0;
    end else begin
      ready_q  <= ready_i;
      ready_qq <= ready_q;
    end
  end

  // R11: ignored unless idle
  assign start = (state_q == ST_IDLE) && ready_q && !ready_qq && !ready_i;

  iso_chan_pick #(.NUM_CHAN(NUM_CHAN), .CH_W(CH_W)) u_pick (
    .pend_i (pend_q),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  iso_hdr_reg #(
    .DATA_W(DATA_W), .ADDR_W(CFG_AW), .HDR_OFFSET(HDR_OFFSET),
    .CH_W(CH_W), .CH_LSB(CH_LSB)
  ) u_hdr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .load_i  (state_q == ST_FETCH),
    .ch_i    (pick_idx),
    .hdr_o   (hdr_o)
  );

  assign take = (state_q == ST_PAYLOAD) && rd_en_i;

  iso_word_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == ST_PRE),
    .inc_i    (take),
    .len_m1_i (len_q),
    .cnt_o    (word_cnt),
    .last_o   (last_word)
  );

  // R1: reset to idle with done high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      len_q   <= '0;
      gap_q   <= '0;
      done_q  <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            done_q  <= 1'b0;
            pend_q  <= chan_mask_i;
            len_q   <= len_m1_i;
            gap_q   <= '0;
            state_q <= (|chan_mask_i) ? ST_FETCH : ST_GAP;
          end
        end
        ST_FETCH: begin
          pend_q[pick_idx] <= 1'b0;
          state_q          <= ST_PRE;
        end
        ST_PRE: state_q <= ST_PAYLOAD;
        ST_PAYLOAD: begin
          if (take && last_word) begin
            gap_q   <= '0;
            state_q <= pick_any ? ST_FETCH : ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_W'(GAP_CYC - 1)) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o      = done_q;
  assign pkt_start_o = (state_q == ST_PRE);
  assign tx_valid_o  = take;
  assign buf_addr_o  = word_cnt;
  assign tx_data_o   = buf_data_i;
endmodule

// File: rtl/iso_tx_seq_chk.sv
module iso_tx_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic              done_o,
  input logic              pkt_start_o,
  input logic              tx_valid_o,
  input logic [DATA_W-1:0] hdr_o
);
  // R5
  pkt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |=> !pkt_start_o);
  // R5
  pkt_no_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |-> !tx_valid_o);
  // R3
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |-> !done_o);
  // R6
  word_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> rd_en_i);
  // R4
  hdr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $stable(hdr_o));
  // R9
  gap_before_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !$past(tx_valid_o));
endmodule

bind iso_tx_seq iso_tx_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_en_i     (rd_en_i),
  .done_o      (done_o),
  .pkt_start_o (pkt_start_o),
  .tx_valid_o  (tx_valid_o),
  .hdr_o       (hdr_o)
);

// File: tb/iso_tx_seq_bench.sv
module iso_tx_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_CYC    = 4;

  typedef struct packed {
    logic [63:0] mask;
    logic [7:0]  len_m1;
    logic [31:0] hdr;
    logic [7:0]  pat;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{64'h0000_0000_0000_0001, 8'd3,   32'h1234_5678, 8'hFF},
    '{64'h8000_0000_0000_0005, 8'd0,   32'hFFFF_FFFF, 8'hFF},
    '{64'h0000_0000_00F0_0000, 8'd5,   32'hA000_00C3, 8'hA6},
    '{64'h8000_0000_0000_0000, 8'd255, 32'h0000_3F00, 8'hFF},
    '{64'h0000_0000_0000_0000, 8'd7,   32'hDEAD_BEEF, 8'hFF},
    '{64'h0000_0100_0000_0002, 8'd2,   32'h5A5A_5A5A, 8'h11}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [63:0] chan_mask_i = '0;
  logic [7:0]  len_m1_i = '0;
  logic        ready_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [31:0] buf_data_i;
  logic        done_o, pkt_start_o, tx_valid_o;
  logic [31:0] hdr_o, tx_data_o;
  logic [7:0]  buf_addr_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign buf_data_i = {16'hC0DE, 8'h00, buf_addr_o};

  iso_tx_seq #(.GAP_CYC(GAP_CYC)) u_iso_tx_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .chan_mask_i(chan_mask_i), .len_m1_i(len_m1_i),
    .ready_i(ready_i), .rd_en_i(rd_en_i), .buf_data_i(buf_data_i),
    .done_o(done_o), .pkt_start_o(pkt_start_o), .hdr_o(hdr_o),
    .buf_addr_o(buf_addr_o), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int next_bit(input logic [63:0] m, input int from);
    for (int i = from; i < 64; i++) if (m[i]) return i;
    return 64;
  endfunction

  task automatic write_cfg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // drives one transfer and follows it word by word
  task automatic run_xfer(input logic [63:0] mask, input logic [7:0] len_m1,
                          input logic [31:0] hdr, input logic [7:0] pat,
                          input int inject);
    int cur = -1, words = 0, pkts = 0, last_cyc = -1, cyc = 0;
    bool_loop: begin end
    chan_mask_i = mask;
    len_m1_i    = len_m1;
    @(negedge clk); ready_i = 1'b1;
    @(negedge clk); ready_i = 1'b0;
    @(negedge clk);
    forever begin
      rd_en_i = pat[cyc % 8];
      if (cyc == inject) ready_i = 1'b1;
      else if (cyc == inject + 1) ready_i = 1'b0;
      #1;
      if (cyc == 0) chk(done_o == 1'b0, "R3 done low after start", done_o, 0);
      if (pkt_start_o) begin
        int e;
        if (cur >= 0) chk(words == int'(len_m1) + 1, "R7 words per packet", words, len_m1 + 1);
        e = next_bit(mask, cur + 1);
        chk(hdr_o == {hdr[31:14], 6'(e), hdr[7:0]}, "R8/R5/R4 header and channel",
            hdr_o, {hdr[31:14], 6'(e), hdr[7:0]});
        cur = e; words = 0; pkts++;
      end
      if (tx_valid_o) begin
        chk(rd_en_i == 1'b1 && cur >= 0, "R6 word only with read-enable", rd_en_i, 1);
        chk(buf_addr_o == 8'(words) && tx_data_o == {16'hC0DE, 8'h00, 8'(words)},
            "R6 word index and data", {buf_addr_o, tx_data_o},
            {8'(words), 16'hC0DE, 8'h00, 8'(words)});
        words++;
        if (words == int'(len_m1) + 1) last_cyc = cyc;
      end
      if (done_o && cyc > 0) break;
      if (cyc > 5000) begin
        chk(1'b0, "R9 transfer never completed", 0, 1);
        break;
      end
      @(negedge clk);
      cyc++;
    end
    rd_en_i = 1'b0;
    ready_i = 1'b0;
    if (cur >= 0) chk(words == int'(len_m1) + 1, "R7 words per packet", words, len_m1 + 1);
    chk(pkts == $countones(mask), "R8 one packet per enabled channel", pkts, $countones(mask));
    chk(cyc - last_cyc == GAP_CYC + 1, "R9/R10 done after idle gap", cyc - last_cyc, GAP_CYC + 1);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(done_o && !pkt_start_o && !tx_valid_o, "R1 state in reset",
        {done_o, pkt_start_o, tx_valid_o}, 3'b100);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(done_o && !pkt_start_o && !tx_valid_o, "R1 state after reset",
        {done_o, pkt_start_o, tx_valid_o}, 3'b100);

    // table of vectors
    for (int v = 0; v < NVEC; v++) begin
      write_cfg(8'h38, VECS[v].hdr);
      run_xfer(VECS[v].mask, VECS[v].len_m1, VECS[v].hdr, VECS[v].pat, -1);
    end

    // R4: write to another offset leaves the header alone
    write_cfg(8'h38, 32'h0BAD_F00D);
    write_cfg(8'h3C, 32'h1111_1111);
    run_xfer(64'h0000_0000_0000_0010, 8'd1, 32'h0BAD_F00D, 8'hFF, -1);

    // R11: ready pulse mid-transfer
    run_xfer(64'h0000_0000_0000_0300, 8'd15, 32'h0BAD_F00D, 8'hFF, 6);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk); #1;
        if (!done_o || pkt_start_o) seen = 1'b1;
      end
      chk(!seen, "R11 mid-transfer pulse starts nothing", seen, 0);
    end

    // R2: ready held two cycles is not a start
    begin
      bit seen = 1'b0;
      chan_mask_i = 64'h1;
      @(negedge clk); ready_i = 1'b1;
      @(negedge clk);
      @(negedge clk); ready_i = 1'b0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk); #1;
        if (!done_o || pkt_start_o) seen = 1'b1;
      end
      chk(!seen, "R2 long ready ignored", seen, 0);
    end

    // R1: reset in mid-transfer
    chan_mask_i = 64'h3;
    len_m1_i    = 8'd20;
    rd_en_i     = 1'b1;
    @(negedge clk); ready_i = 1'b1;
    @(negedge clk); ready_i = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    chk(!done_o && tx_valid_o, "R1 transfer running before reset",
        {done_o, tx_valid_o}, 2'b01);
    rst_ni = 1'b0;
    #1;
    chk(done_o && !tx_valid_o && !pkt_start_o, "R1 reset mid-transfer",
        {done_o, pkt_start_o, tx_valid_o}, 3'b100);
    @(negedge clk); rst_ni = 1'b1; rd_en_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(done_o && !tx_valid_o && !pkt_start_o, "R1 idle after reset release",
        {done_o, pkt_start_o, tx_valid_o}, 3'b100);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule